// File: doc/BRIEF.md
# Packet VM Instruction Legality Checker

This block screens one 64-bit basic-format instruction word of a packet-filter virtual machine and says whether the opcode, together with its register, offset and immediate fields, forms a legal instruction. A loader or verifier front end presents one word per cycle with a valid strobe. One clock edge later the block returns a valid flag, an illegal flag and a reason code. The word is laid out as imm[63:32], offset[31:16], src[15:12], dst[11:8], opcode[7:0]. The instruction class is opcode[2:0].

The full rules are applied to arithmetic (32-bit and 64-bit classes), byte swap, register loads, immediate stores, register stores and atomic stores. Wide-immediate loads (class 0) and the two branch classes (5 and 6) are only classified and always reported legal. The block has no program-flow or memory model. The checking is a single decode cone followed by one output register. Its results are: OK (idle or legal word), bad opcode, bad immediate, nonzero unused field and bad register. A word that breaks several rules reports the first in that order.

Top module: `pvm_opcode_checker`

## Requirements
- R1: out_valid equals in_valid delayed by one clock. While out_valid is low, out_illegal and out_reason are 0. Reset clears all three outputs.
- R2: out_illegal is 1 exactly when out_reason is nonzero. Reason encoding: 0 OK, 1 bad opcode, 2 bad immediate, 3 nonzero unused field, 4 bad register.
- R3: Words of class 0, 5 or 6 (opcode[2:0]) are reported legal whatever their other fields hold.
- R4: Arithmetic classes 4 and 7 use operation code opcode[7:4] and source bit opcode[3]. Codes 14 and 15, and negate (code 8) with the source bit set, give reason 1. When the source bit is 0, src and offset must be zero. When it is 1, imm and offset must be zero. Negate additionally requires src, offset and imm all zero. A violation of these zero rules gives reason 3.
- R5: Byte swap (code 13) is legal only as 0xd4 or 0xdc. The 64-bit-class forms 0xd7 and 0xdf give reason 1.
- R6: For byte swap, imm must be 16, 32 or 64, otherwise reason 2. src and offset must be zero, otherwise reason 3.
- R7: Class 1 is legal only as 0x61, 0x69, 0x71 or 0x79 (word, half, byte, double word), otherwise reason 1. imm must be zero, otherwise reason 3.
- R8: Class 2 is legal only as 0x62, 0x6a, 0x72 or 0x7a. Every other class-2 opcode, including atomic-mode ones, gives reason 1. src must be zero, otherwise reason 3.
- R9: Class 3 in regular memory mode (0x63, 0x6b, 0x73, 0x7b) requires imm zero, otherwise reason 3.
- R10: Atomic stores are legal only as 0xc3 and 0xdb. Other atomic sizes such as 0xcb and 0xd3, and any other class-3 mode, give reason 1. For atomics the imm must be one of 0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xa0, 0xa1, 0xe1 or 0xf1, otherwise reason 2.
- R11: These register rules give reason 4. A dst above 10 is illegal. A dst equal to 10 is illegal for arithmetic and load words. A src above 10 is illegal on every form that reads src: register-source arithmetic, loads, register stores and atomics.
- R12: When several rules fail, the reported reason is the lowest-numbered one (1 before 2 before 3 before 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_insn | input | 64 | Instruction word |
| out_valid | output | 1 | Result for the word presented one cycle earlier |
| out_illegal | output | 1 | Word violates a rule |
| out_reason | output | 3 | Reason code, 0 when legal or idle |

## Verification
Every result (valid, illegal flag and reason) appears exactly one clock edge after its word is presented. No result depends on more than one word. The bench drives each word on a falling edge and reads all three outputs on the next falling edge, half a period after the capturing edge. Expected codes come from a bench-side reference written from the requirements. Directed corner words for byte swap, atomics, the frame register and priority are mixed with seeded random words.

// File: rtl/pvm_chk_pkg.sv
package pvm_chk_pkg;

    localparam int OPC_W = 8;
    localparam int REG_W = 4;
    localparam int OFF_W = 16;
    localparam int IMM_W = 32;
    localparam int INSN_W = OPC_W + 2 * REG_W + OFF_W + IMM_W;
    localparam int RSN_W = 3;

    typedef enum logic [RSN_W-1:0] {
        RSN_OK      = 3'd0,
        RSN_BAD_OP  = 3'd1,
        RSN_BAD_IMM = 3'd2,
        RSN_UNUSED  = 3'd3,
        RSN_BAD_REG = 3'd4
    } reason_e;

    typedef enum logic [2:0] {
        CLS_WIDE     = 3'd0,
        CLS_LOADR    = 3'd1,
        CLS_STIMM    = 3'd2,
        CLS_STREG    = 3'd3,
        CLS_ARITH32  = 3'd4,
        CLS_BRANCH   = 3'd5,
        CLS_BRANCH32 = 3'd6,
        CLS_ARITH64  = 3'd7
    } cls_e;

    typedef struct packed {
        logic [IMM_W-1:0] imm;
        logic [OFF_W-1:0] off;
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
        logic [OPC_W-1:0] opc;
    } insn_t;

    // lowest-numbered failing rule wins
    function automatic reason_e rank(input logic bad_op, input logic bad_imm,
                                     input logic unused, input logic bad_reg);
        if (bad_op)       return RSN_BAD_OP;
        else if (bad_imm) return RSN_BAD_IMM;
        else if (unused)  return RSN_UNUSED;
        else if (bad_reg) return RSN_BAD_REG;
        return RSN_OK;
    endfunction

endpackage

// File: rtl/pvm_arith_rules.sv
module pvm_arith_rules
    import pvm_chk_pkg::*;
#(
    parameter int MAX_REG   = 10,
    parameter int FRAME_REG = 10
) (
    input  insn_t   word,
    output reason_e reason
);
    localparam logic [3:0] OP_NEG  = 4'd8;
    localparam logic [3:0] OP_SWAP = 4'd13;
    localparam logic [3:0] OP_LAST = 4'd13;

    logic [3:0] op;
    logic       use_reg;
    logic       is_wide;
    logic       is_swap, is_neg;
    logic       bad_op, bad_imm, unused, bad_reg;

    always_comb begin
        op      = word.opc[7:4];
        use_reg = word.opc[3];
        is_wide = (word.opc[2:0] == CLS_ARITH64);
        is_swap = (op == OP_SWAP);
        is_neg  = (op == OP_NEG);

        // opcode: undefined codes, 64-bit byte swap, negate with register source
        bad_op = (op > OP_LAST) || (is_swap && is_wide) || (is_neg && use_reg);

        bad_imm = is_swap && !(word.imm == 32'd16 || word.imm == 32'd32 ||
                               word.imm == 32'd64);

        if (is_swap)
            unused = (word.src != '0) || (word.off != '0);
        else if (is_neg)
            unused = (word.src != '0) || (word.off != '0) || (word.imm != '0);
        else if (use_reg)
            unused = (word.imm != '0) || (word.off != '0);
        else
            unused = (word.src != '0) || (word.off != '0);

        bad_reg = (int'(word.dst) > MAX_REG) || (int'(word.dst) == FRAME_REG) ||
                  (use_reg && !is_swap && !is_neg && int'(word.src) > MAX_REG);

        reason = rank(bad_op, bad_imm, unused, bad_reg);
    end

endmodule

// File: rtl/pvm_mem_rules.sv
module pvm_mem_rules
    import pvm_chk_pkg::*;
#(
    parameter int MAX_REG   = 10,
    parameter int FRAME_REG = 10
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src,
    input  logic [IMM_W-1:0] imm,
    output reason_e          reason
);
    localparam logic [2:0] MODE_PLAIN  = 3'd3;
    localparam logic [2:0] MODE_ATOMIC = 3'd6;
    localparam logic [1:0] SZ_WORD     = 2'd0;
    localparam logic [1:0] SZ_DWORD    = 2'd3;

    logic [2:0] mode;
    logic [1:0] size;
    cls_e       cls;
    logic       dst_hi, src_hi;
    logic       atom_imm_ok;
    logic       bad_op, bad_imm, unused, bad_reg;

    always_comb begin
        mode   = opc[7:5];
        size   = opc[4:3];
        cls    = cls_e'(opc[2:0]);
        dst_hi = int'(dst) > MAX_REG;
        src_hi = int'(src) > MAX_REG;

        atom_imm_ok = 1'b0;
        if (imm[IMM_W-1:8] == '0) begin
            unique case (imm[7:0])
                8'h00, 8'h01, 8'h40, 8'h41, 8'h50,
                8'h51, 8'ha0, 8'ha1, 8'he1, 8'hf1: atom_imm_ok = 1'b1;
                default:                           atom_imm_ok = 1'b0;
            endcase
        end

        bad_op  = 1'b0;
        bad_imm = 1'b0;
        unused  = 1'b0;
        bad_reg = 1'b0;
        unique case (cls)
            CLS_LOADR: begin
                bad_op  = (mode != MODE_PLAIN);
                unused  = (imm != '0);
                bad_reg = dst_hi || (int'(dst) == FRAME_REG) || src_hi;
            end
            CLS_STIMM: begin
                bad_op  = (mode != MODE_PLAIN);
                unused  = (src != '0);
                bad_reg = dst_hi;
            end
            CLS_STREG: begin
                if (mode == MODE_PLAIN) begin
                    unused = (imm != '0);
                end else if (mode == MODE_ATOMIC) begin
                    bad_op  = !(size == SZ_WORD || size == SZ_DWORD);
                    bad_imm = !atom_imm_ok;
                end else begin
                    bad_op = 1'b1;
                end
                bad_reg = dst_hi || src_hi;
            end
            default: ;
        endcase

        reason = rank(bad_op, bad_imm, unused, bad_reg);
    end

endmodule

// File: rtl/pvm_opcode_checker.sv
module pvm_opcode_checker
    import pvm_chk_pkg::*;
#(
    parameter int MAX_REG   = 10,
    parameter int FRAME_REG = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [RSN_W-1:0]  out_reason
);
    insn_t   word;
    cls_e    cls;
    reason_e arith_rsn, mem_rsn, next_rsn;
    reason_e rsn_q;
    logic    valid_q, illegal_q;

    assign word = insn_t'(in_insn);
    assign cls  = cls_e'(word.opc[2:0]);

    pvm_arith_rules #(.MAX_REG(MAX_REG), .FRAME_REG(FRAME_REG)) u_arith (
        .word   (word),
        .reason (arith_rsn)
    );

    pvm_mem_rules #(.MAX_REG(MAX_REG), .FRAME_REG(FRAME_REG)) u_mem (
        .opc    (word.opc),
        .dst    (word.dst),
        .src    (word.src),
        .imm    (word.imm),
        .reason (mem_rsn)
    );

    always_comb begin
        unique case (cls)
            CLS_ARITH32, CLS_ARITH64:         next_rsn = arith_rsn;
            CLS_LOADR, CLS_STIMM, CLS_STREG:  next_rsn = mem_rsn;
            default:                          next_rsn = RSN_OK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            rsn_q     <= RSN_OK;
        end else begin
            valid_q   <= in_valid;
            illegal_q <= in_valid && (next_rsn != RSN_OK);
            rsn_q     <= in_valid ? next_rsn : RSN_OK;
        end
    end

    assign out_valid   = valid_q;
    assign out_illegal = illegal_q;
    assign out_reason  = rsn_q;

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal && out_reason == '0));
    assert_flag_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_illegal == (out_reason != '0) && out_reason <= 3'd4));
    assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_insn[2:0] == 3'd0 || in_insn[2:0] == 3'd5 || in_insn[2:0] == 3'd6))
        |=> !out_illegal);
    assert_swap64_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_insn[7:0] == 8'hd7 || in_insn[7:0] == 8'hdf))
        |=> out_reason == 3'd1);
    assert_atomic_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_insn[7:0] == 8'hd3 || in_insn[7:0] == 8'hcb))
        |=> out_reason == 3'd1);

endmodule

// File: tb/tb_pvm_opcode_checker.sv
`timescale 1ns/1ps
module tb_pvm_opcode_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_insn = '0;
    logic        out_valid, out_illegal;
    logic [2:0]  out_reason;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pvm_opcode_checker dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_reason(out_reason)
    );

    function automatic logic [63:0] mk(logic [7:0] op, logic [3:0] d, logic [3:0] s,
                                       logic [15:0] o, logic [31:0] i);
        return {i, o, s, d, op};
    endfunction

    // reference model written from the requirements
    function automatic int ref_rsn(logic [63:0] w);
        logic [7:0] op = w[7:0];
        int d = int'(w[11:8]);
        int s = int'(w[15:12]);
        logic [15:0] o = w[31:16];
        logic [31:0] i = w[63:32];
        int cls = int'(op[2:0]);
        int code = int'(op[7:4]);
        bit bo = 0, bi = 0, un = 0, br = 0;
        if (cls == 4 || cls == 7) begin
            if (code >= 14) bo = 1;
            if (code == 13 && cls == 7) bo = 1;
            if (code == 8 && op[3]) bo = 1;
            if (code == 13) begin
                bi = !(i == 16 || i == 32 || i == 64);
                un = (s != 0) || (o != 0);
            end else if (code == 8) un = (s != 0) || (o != 0) || (i != 0);
            else if (op[3]) un = (i != 0) || (o != 0);
            else un = (s != 0) || (o != 0);
            br = (d >= 10) || (op[3] && code != 13 && code != 8 && s > 10);
        end else if (cls == 1) begin
            bo = (op[7:5] != 3'd3);
            un = (i != 0);
            br = (d >= 10) || (s > 10);
        end else if (cls == 2) begin
            bo = (op[7:5] != 3'd3);
            un = (s != 0);
            br = (d > 10);
        end else if (cls == 3) begin
            if (op[7:5] == 3'd3) un = (i != 0);
            else if (op == 8'hc3 || op == 8'hdb)
                bi = !(i inside {32'h00, 32'h01, 32'h40, 32'h41, 32'h50,
                                 32'h51, 32'ha0, 32'ha1, 32'he1, 32'hf1});
            else bo = 1;
            br = (d > 10) || (s > 10);
        end
        if (bo) return 1;
        if (bi) return 2;
        if (un) return 3;
        if (br) return 4;
        return 0;
    endfunction

    task automatic check(string tag, bit v, bit ill, int rsn);
        n_chk++;
        if (out_valid !== v || out_illegal !== ill || int'(out_reason) != rsn) begin
            n_bad++;
            $display("FAIL %s: got v=%0b ill=%0b rsn=%0d, expected v=%0b ill=%0b rsn=%0d",
                     tag, out_valid, out_illegal, out_reason, v, ill, rsn);
        end
    endtask

    // called at a falling edge; result is read at the next falling edge
    task automatic apply(logic [63:0] w, string tag);
        int e = ref_rsn(w);
        in_valid = 1'b1;
        in_insn  = w;
        @(negedge clk);
        check(tag, 1'b1, e != 0, e);
    endtask

    task automatic expect_code(logic [63:0] w, int e, string tag);
        int r = ref_rsn(w);
        n_chk++;
        if (r != e) begin
            n_bad++;
            $display("FAIL %s model: got %0d expected %0d", tag, r, e);
        end
        apply(w, tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] picks [24] = '{8'h0c, 8'h07, 8'h87, 8'h8f, 8'he4, 8'hd4, 8'hdc, 8'hd7,
                                   8'h61, 8'h69, 8'h79, 8'h41, 8'h62, 8'h7a, 8'hc2, 8'h63,
                                   8'h7b, 8'hc3, 8'hdb, 8'hd3, 8'hcb, 8'h95, 8'h18, 8'h2e};
        logic [31:0] imms [8] = '{32'd0, 32'd16, 32'd32, 32'd64, 32'h50, 32'ha0, 32'he1, 32'd7};
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 1'b0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", 1'b0, 1'b0, 0);

        expect_code(mk(8'h95, 4'd15, 4'd15, 16'h1, 32'h9), 0, "R3 branch passthru");
        expect_code(mk(8'h18, 4'd12, 4'd0, 16'h0, 32'h5), 0, "R3 wide passthru");
        expect_code(mk(8'h0c, 4'd1, 4'd2, 16'h0, 32'h0), 0, "R4 add reg");
        expect_code(mk(8'hec, 4'd1, 4'd2, 16'h0, 32'h0), 1, "R4 undefined code");
        expect_code(mk(8'h8f, 4'd1, 4'd0, 16'h0, 32'h0), 1, "R4 neg with src bit");
        expect_code(mk(8'h04, 4'd1, 4'd3, 16'h0, 32'h5), 3, "R4 imm form src set");
        expect_code(mk(8'hd4, 4'd2, 4'd0, 16'h0, 32'd16), 0, "R5 le16 legal");
        expect_code(mk(8'hdc, 4'd2, 4'd0, 16'h0, 32'd64), 0, "R5 be64 legal");
        expect_code(mk(8'hd7, 4'd2, 4'd0, 16'h0, 32'd16), 1, "R5 swap in 64 class");
        expect_code(mk(8'hdf, 4'd2, 4'd0, 16'h0, 32'd32), 1, "R5 swap in 64 class be");
        expect_code(mk(8'hdc, 4'd2, 4'd0, 16'h0, 32'd48), 2, "R6 swap width");
        expect_code(mk(8'hd4, 4'd2, 4'd0, 16'h4, 32'd32), 3, "R6 swap offset");
        expect_code(mk(8'h71, 4'd3, 4'd4, 16'h8, 32'h0), 0, "R7 byte load");
        expect_code(mk(8'h61, 4'd3, 4'd4, 16'h0, 32'h5), 3, "R7 load imm set");
        expect_code(mk(8'h41, 4'd3, 4'd4, 16'h0, 32'h0), 1, "R7 load bad mode");
        expect_code(mk(8'h6a, 4'd10, 4'd0, 16'h2, 32'h77), 0, "R8 imm store on frame");
        expect_code(mk(8'hc2, 4'd1, 4'd0, 16'h0, 32'h0), 1, "R8 atomic via imm store");
        expect_code(mk(8'h72, 4'd1, 4'd5, 16'h0, 32'h1), 3, "R8 src set");
        expect_code(mk(8'h7b, 4'd1, 4'd5, 16'h0, 32'h1), 3, "R9 reg store imm set");
        expect_code(mk(8'hc3, 4'd1, 4'd2, 16'h0, 32'h50), 0, "R10 atomic and");
        expect_code(mk(8'hdb, 4'd1, 4'd2, 16'h0, 32'ha0), 0, "R10 atomic xor");
        expect_code(mk(8'hd3, 4'd1, 4'd2, 16'h0, 32'h50), 1, "R10 byte atomic");
        expect_code(mk(8'hcb, 4'd1, 4'd2, 16'h0, 32'h00), 1, "R10 half atomic");
        expect_code(mk(8'hc3, 4'd1, 4'd2, 16'h0, 32'h30), 2, "R10 atomic op code");
        expect_code(mk(8'h07, 4'd10, 4'd0, 16'h0, 32'h1), 4, "R11 alu frame dst");
        expect_code(mk(8'h07, 4'd11, 4'd0, 16'h0, 32'h1), 4, "R11 dst above max");
        expect_code(mk(8'h63, 4'd1, 4'd14, 16'h0, 32'h0), 4, "R11 src above max");
        expect_code(mk(8'hd7, 4'd12, 4'd0, 16'h0, 32'd7), 1, "R12 op before imm");
        expect_code(mk(8'hdc, 4'd12, 4'd3, 16'h0, 32'd7), 2, "R12 imm before unused");
        expect_code(mk(8'h61, 4'd12, 4'd0, 16'h0, 32'd1), 3, "R12 unused before reg");

        in_valid = 1'b0;
        @(negedge clk);
        check("R1 idle after burst", 1'b0, 1'b0, 0);

        for (int k = 0; k < 600; k++) begin
            logic [7:0]  op = ($urandom % 4 == 0) ? 8'($urandom) : picks[$urandom % 24];
            logic [3:0]  d  = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 10);
            logic [3:0]  s  = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 3);
            logic [15:0] o  = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
            logic [31:0] i  = ($urandom % 5 == 0) ? $urandom : imms[$urandom % 8];
            apply(mk(op, d, s, o, i), "R12 random word");
            if ($urandom % 8 == 0) begin
                in_valid = 1'b0;
                in_insn  = {$urandom, $urandom};
                @(negedge clk);
                check("R1 random idle", 1'b0, 1'b0, 0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule